// File: doc/BRIEF.md
# Grouped carry-increment adder

This block is a purely combinational two-operand binary adder with a carry input, producing an N-bit sum and a carry output. The operand width is cut into consecutive bit groups whose widths come from a parameter list. The widths need not be equal, and the default list makes them grow toward the most significant end.

Inside every group, a ripple chain of bit slices forms a partial sum that assumes no carry enters the group. When the carry that actually enters the group is 1, the partial sum is incremented. Each group passes a carry to its neighbour. That carry is either the ripple chain's own carry, or the incoming carry when every operand bit pair in the group differs.

The block uses only two kinds of bit slice. The lowest bit of a group uses an incrementing half-adder slice, and every other bit uses an incrementing full-adder slice. The block is meant to sit in a datapath where the late-arriving signal is the carry. Group widths are chosen so that the carry across the lower groups arrives at about the same time as each group's own internal ripple finishes.

Top module: `cia_adder`

## Requirements
- R1: For every a, b and cin, the value {cout, sum} equals a + b + cin, taken as an (N+1)-bit unsigned result.
- R2: With a all ones, b zero and cin 1, the sum is all zeros and cout is 1, because the carry crosses every group.
- R3: In each group, the partial result equals the group's slice of a plus the group's slice of b, taken modulo 2^width, with no carry added.
- R4: In each group, the sum slice equals the partial result plus the carry entering the group, taken modulo 2^width. With both operands zero and cin 1, the sum is 1.
- R5: The carry that leaves a group equals the carry out of the group's slice of a plus its slice of b plus the carry entering the group.
- R6: When a XOR b is all ones across a group, the carry that leaves that group equals the carry that enters it.
- R7: Groups are laid out from bit 0 upward in list order. Byte k of GRP_SIZES (bits 8k+7 down to 8k) holds the width of group k. The default widths are 5, 7, 9 and 11, so the group tops are at bits 4, 11, 20 and 31. A carry generated at a group's top bit appears at the base of the next group, or on cout for the top group.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | N | First operand |
| b | input | N | Second operand |
| cin | input | 1 | Carry into bit 0 |
| sum | output | N | Low N bits of a + b + cin |
| cout | output | 1 | Carry out of the top bit |

## Verification
The checks assume that a, b and cin are stable and carry known values when they are evaluated. They also assume that the entries of GRP_SIZES for the first NG groups add up to exactly N. The stimulus is only ever changed a nanosecond after a clock edge and is sampled half a period later, so every group has settled before it is observed. The default group list covers all 32 bits, so the group-level checks see every bit. The directed vectors place generate, propagate and kill patterns on each group boundary, so the carry-forwarding and propagate-bypass relations are exercised in both states.

// File: rtl/cia_pkg.sv
package cia_pkg;
  localparam int unsigned MAX_GRP = 16;
  localparam int unsigned SZ_BITS = 8;
  typedef logic [MAX_GRP*SZ_BITS-1:0] grp_list_t;

  // width of group k (byte k of the list)
  function automatic int unsigned grp_width(grp_list_t lst, int unsigned k);
    return 32'(lst[k*SZ_BITS +: SZ_BITS]);
  endfunction

  // first bit of group k
  function automatic int unsigned grp_base(grp_list_t lst, int unsigned k);
    int unsigned acc;
    acc = 0;
    for (int unsigned i = 0; i < k; i++) acc += grp_width(lst, i);
    return acc;
  endfunction
endpackage

// File: rtl/cia_pg_stage.sv
module cia_pg_stage #(
  parameter int unsigned N = 32
) (
  input  logic [N-1:0] opa,
  input  logic [N-1:0] opb,
  output logic [N-1:0] prop,
  output logic [N-1:0] gen
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    assign prop[i] = opa[i] ^ opb[i];
    assign gen[i]  = opa[i] & opb[i];
  end
endmodule

// File: rtl/cia_iha_cell.sv
// Lowest slice of a group: half-adder partial bit plus increment.
module cia_iha_cell (
  input  logic p,
  input  logic g,
  input  logic grp_cin,
  input  logic pp_in,
  output logic part_s,
  output logic c_out,
  output logic s,
  output logic pp_out
);
  assign part_s = p;
  assign c_out  = g;
  assign s      = part_s ^ (grp_cin & pp_in);
  assign pp_out = pp_in & p;
endmodule

// File: rtl/cia_ifa_cell.sv
// Upper slice of a group: full-adder partial bit plus increment.
module cia_ifa_cell (
  input  logic p,
  input  logic g,
  input  logic c_in,
  input  logic grp_cin,
  input  logic pp_in,
  output logic part_s,
  output logic c_out,
  output logic s,
  output logic pp_out
);
  assign part_s = p ^ c_in;
  assign c_out  = g | (p & c_in);
  assign s      = part_s ^ (grp_cin & pp_in);
  assign pp_out = pp_in & p;
endmodule

// File: rtl/cia_group.sv
module cia_group #(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] p,
  input  logic [W-1:0] g,
  input  logic         grp_cin,
  output logic [W-1:0] sum,
  output logic [W-1:0] part,
  output logic         grp_cout
);
  logic [W:1] c;   // internal ripple carry into bit i
  logic [W:0] pp;  // prefix propagate of bits below i

  assign pp[0] = 1'b1;

  for (genvar i = 0; i < W; i++) begin : g_slice
    if (i == 0) begin : g_ha
      cia_iha_cell u_cell (
        .p(p[i]), .g(g[i]), .grp_cin(grp_cin), .pp_in(pp[i]),
        .part_s(part[i]), .c_out(c[i+1]), .s(sum[i]), .pp_out(pp[i+1])
      );
    end else begin : g_fa
      cia_ifa_cell u_cell (
        .p(p[i]), .g(g[i]), .c_in(c[i]), .grp_cin(grp_cin), .pp_in(pp[i]),
        .part_s(part[i]), .c_out(c[i+1]), .s(sum[i]), .pp_out(pp[i+1])
      );
    end
  end

  // group carry: internal carry, or incoming carry through an all-propagate group
  assign grp_cout = c[W] | (grp_cin & pp[W]);
endmodule

// File: rtl/cia_adder.sv
module cia_adder #(
  parameter int unsigned       N         = 32,
  parameter int unsigned       NG        = 4,
  parameter cia_pkg::grp_list_t GRP_SIZES = 128'h0B_09_07_05
) (
  input  logic [N-1:0] a,
  input  logic [N-1:0] b,
  input  logic         cin,
  output logic [N-1:0] sum,
  output logic         cout
);
  logic [N-1:0] prop;
  logic [N-1:0] gen;
  logic [N-1:0] part;
  logic [NG:0]  grp_c;

  cia_pg_stage #(.N(N)) u_pg (
    .opa(a), .opb(b), .prop(prop), .gen(gen)
  );

  assign grp_c[0] = cin;

  for (genvar k = 0; k < NG; k++) begin : g_grp
    localparam int unsigned GW = cia_pkg::grp_width(GRP_SIZES, k);
    localparam int unsigned GB = cia_pkg::grp_base(GRP_SIZES, k);
    cia_group #(.W(GW)) u_group (
      .p       (prop[GB +: GW]),
      .g       (gen[GB +: GW]),
      .grp_cin (grp_c[k]),
      .sum     (sum[GB +: GW]),
      .part    (part[GB +: GW]),
      .grp_cout(grp_c[k+1])
    );
  end

  assign cout = grp_c[NG];
endmodule

// File: rtl/cia_adder_chk.sv
module cia_adder_chk #(
  parameter int unsigned       N         = 32,
  parameter int unsigned       NG        = 4,
  parameter cia_pkg::grp_list_t GRP_SIZES = 128'h0B_09_07_05
) (
  input logic [N-1:0] a,
  input logic [N-1:0] b,
  input logic         cin,
  input logic [N-1:0] sum,
  input logic         cout,
  input logic [N-1:0] part,
  input logic [NG:0]  grp_c
);
  logic [N:0] ref_total;
  assign ref_total = {1'b0, a} + {1'b0, b} + {{N{1'b0}}, cin};

  always_comb begin
    assert_total_matches_R1: assert ({cout, sum} == ref_total)
      else $error("R1: adder result %h differs from %h", {cout, sum}, ref_total);
  end

  for (genvar k = 0; k < NG; k++) begin : g_grp
    localparam int unsigned GW = cia_pkg::grp_width(GRP_SIZES, k);
    localparam int unsigned GB = cia_pkg::grp_base(GRP_SIZES, k);
    logic [GW:0] raw_k;   // slice sum without carry
    logic [GW:0] full_k;  // slice sum with the group's carry
    logic [GW:0] inc_k;   // partial plus group carry
    assign raw_k  = {1'b0, a[GB +: GW]} + {1'b0, b[GB +: GW]};
    assign full_k = raw_k + {{GW{1'b0}}, grp_c[k]};
    assign inc_k  = {1'b0, part[GB +: GW]} + {{GW{1'b0}}, grp_c[k]};

    always_comb begin
      assert_partial_carry_free_R3: assert (part[GB +: GW] == raw_k[GW-1:0])
        else $error("R3: group %0d partial wrong", k);
      assert_increment_R4: assert (sum[GB +: GW] == inc_k[GW-1:0])
        else $error("R4: group %0d increment wrong", k);
      assert_group_carry_R5: assert (grp_c[k+1] == full_k[GW])
        else $error("R5: group %0d carry-out wrong", k);
      if (&(a[GB +: GW] ^ b[GB +: GW])) begin
        assert_bypass_R6: assert (grp_c[k+1] == grp_c[k])
          else $error("R6: group %0d bypass wrong", k);
      end
    end
  end
endmodule

bind cia_adder cia_adder_chk #(.N(N), .NG(NG), .GRP_SIZES(GRP_SIZES)) i_chk (
  .a(a), .b(b), .cin(cin), .sum(sum), .cout(cout), .part(part), .grp_c(grp_c)
);

// File: tb/test_cia_adder.sv
module test_cia_adder;
  localparam int unsigned N = 32;

  logic clk;
  logic [N-1:0] a_r, b_r, sum_w;
  logic cin_r, cout_w;
  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit finished = 0;

  cia_adder i_cia_adder (
    .a(a_r), .b(b_r), .cin(cin_r), .sum(sum_w), .cout(cout_w)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  // {a, b, cin}; expected results come from the behavioural add
  localparam logic [2*N:0] VEC [12] = '{
    {32'h0000_0000, 32'h0000_0000, 1'b0},
    {32'hFFFF_FFFF, 32'h0000_0000, 1'b1},
    {32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1},
    {32'hAAAA_AAAA, 32'h5555_5555, 1'b0},
    {32'hAAAA_AAAA, 32'h5555_5555, 1'b1},
    {32'h5555_5555, 32'h5555_5555, 1'b0},
    {32'h0000_0010, 32'h0000_0010, 1'b0},
    {32'h0000_0800, 32'h0000_0800, 1'b0},
    {32'h0010_0000, 32'h0010_0000, 1'b0},
    {32'h8000_0000, 32'h8000_0000, 1'b0},
    {32'h0000_001F, 32'h0000_0001, 1'b0},
    {32'h7FFF_FFFF, 32'h0000_0001, 1'b1}
  };

  task automatic check(input string tag, input logic [N:0] act, input logic [N:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic apply(input string tag, input logic [N-1:0] va, input logic [N-1:0] vb,
                       input logic vc);
    logic [N:0] exp;
    @(posedge clk);
    #1;
    a_r = va; b_r = vb; cin_r = vc;
    exp = {1'b0, va} + {1'b0, vb} + {{N{1'b0}}, vc};
    @(negedge clk);
    check(tag, {cout_w, sum_w}, exp);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      total++;
      bad++;
      $display("FAIL watchdog: got %0d cycles expected fewer than 100000", cycles);
      finish_run();
    end
  end

  initial begin
    a_r = '0; b_r = '0; cin_r = 1'b0;

    // R1: table of mixed patterns
    for (int i = 0; i < 12; i++) begin
      apply("R1 table", VEC[i][2*N:N+1], VEC[i][N:1], VEC[i][0]);
    end

    // R2: all ones plus carry-in, in both operand orders
    apply("R2 ones+cin", 32'hFFFF_FFFF, 32'h0000_0000, 1'b1);
    apply("R2 ones+cin swapped", 32'h0000_0000, 32'hFFFF_FFFF, 1'b1);

    // R3: operands confined to group 2 with no carry in
    apply("R3 group2 slice", 32'h0005_A000, 32'h0002_3000, 1'b0);

    // R4: increment of a zero partial, and of an all-ones partial in group 0
    apply("R4 zero+cin", 32'h0000_0000, 32'h0000_0000, 1'b1);
    apply("R4 group0 wrap", 32'h0000_0015, 32'h0000_000A, 1'b1);

    // R5: a group that generates, and one that kills, its carry
    apply("R5 generate", 32'h0000_0FE0, 32'h0000_0020, 1'b0);
    apply("R5 kill", 32'h0000_0000, 32'h0000_0000, 1'b1);

    // R6: group 1 all propagate, fed by a carry from group 0
    apply("R6 bypass group1", 32'h0000_0FFF, 32'h0000_0001, 1'b0);
    apply("R6 bypass all", 32'hAAAA_AAAA, 32'h5555_5555, 1'b1);

    // R7: generate at the top bit of each default group
    apply("R7 top of group0", 32'h0000_0010, 32'h0000_0010, 1'b0);
    apply("R7 top of group1", 32'h0000_0800, 32'h0000_0800, 1'b0);
    apply("R7 top of group2", 32'h0010_0000, 32'h0010_0000, 1'b0);
    apply("R7 top of group3", 32'h8000_0000, 32'h8000_0000, 1'b0);

    // R1: random operands
    for (int i = 0; i < 3000; i++) begin
      apply("R1 random", $urandom(), $urandom(), 1'($urandom() & 1));
    end

    finish_run();
  end
endmodule